// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File with Interrupt Status

This block is the host-facing register file of a real-time clock. It holds 128 bytes behind a two-address port. A write to the even address picks a byte index. A read or write at the odd address then reaches the byte at that index. Among those bytes are two control registers, two status registers and three alarm bytes. The calendar counter and the periodic-rate divider sit outside the block. They report to it through three single-cycle pulses (periodic tick, update start, update end) and through the current seconds, minutes and hours bytes. They also read the two control registers back through dedicated outputs.

The host side is a valid/ready stream. A request carries the address bit, a write flag and a data byte. It is accepted on any cycle where `req_valid` and `req_ready` are both high. Every accepted read produces exactly one response beat, one cycle later. That beat stays valid, with its data frozen, until `rsp_ready` is seen high. While an unconsumed response is waiting and `rsp_ready` is low, `req_ready` is low, so at most one response is ever pending. Writes produce no response.

The block keeps an update-in-progress flag and an interrupt status byte, and drives one interrupt line. The status byte is cleared by reading it.

Top module: `rtcx_regfile`

## Requirements
- R1: An accepted write with `req_addr`=0 stores `req_wdata[6:0]` as the index. An accepted odd-address (`req_addr`=1) write to any index other than 10, 12 or 13 stores the full byte, and a later odd read of that index returns it. An even-address read returns 0xFF.
- R2: After reset:
  - index 10 (control A) reads 0x26 and index 11 (control B) reads 0x02;
  - index 12 (status) reads 0x00 and index 13 reads 0x80;
  - `irq` is low and `ctl_a`/`ctl_b` equal 0x26/0x02.
- R3: Bit 7 of control A is the update-in-progress flag. A write to index 10 takes bits 6:0 from the data and leaves bit 7 unchanged.
- R4: The update-in-progress flag changes as follows:
  - `upd_start` sets it one cycle later when control B bit 7 (freeze) is low;
  - `upd_end` clears it;
  - a write to index 11 with data bit 7 high clears it, and this wins over an `upd_start` in the same cycle.
- R5: `tick_periodic` with control B bit 6 high ORs 0xC0 into the status byte. With bit 6 low it has no effect.
- R6: `upd_end` with control B bit 7 low and bit 4 high ORs 0x90 into the status byte.
- R7: On `upd_end` with control B bit 7 low and bit 5 high, the block checks the three alarm bytes: index 1 against `cur_sec`, index 3 against `cur_min`, index 5 against `cur_hour`. A byte matches when its bits 7:6 are both 1, or when it equals its field. If all three match, 0xA0 is ORed into the status byte.
- R8: An odd read of index 12 returns the status value before the edge and clears it at that edge. Flags set by events in the same cycle survive the clear. `irq` equals status bit 7.
- R9: Writes to index 12 and index 13 are ignored.
- R10: `req_ready` is low exactly while a response is pending and `rsp_ready` is low. A pending response keeps `rsp_valid` high and `rsp_data` stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request can be accepted |
| req_addr | input | 1 | 0 selects the index port, 1 the data port |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 8 | Read response data |
| tick_periodic | input | 1 | Periodic divider pulse |
| upd_start | input | 1 | Calendar update begins (pulse) |
| upd_end | input | 1 | Calendar update done (pulse) |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| ctl_a | output | 8 | Control A including update-in-progress flag |
| ctl_b | output | 8 | Control B |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the event inputs to be single-cycle pulses. They also assume that `upd_start` and `upd_end` never arrive in the same cycle, since the update-in-progress properties are written for one of the two at a time. The stimulus draws both pulses from one random choice, so at most one of them fires per cycle. Random alarm and time bytes come from a small pool that contains wildcard codes, which makes both matches and misses frequent.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
  localparam int IDX_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 1 << IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Byte indices whose behaviour is fixed.
  localparam idx_t IDX_ALM_SEC  = 7'd1;
  localparam idx_t IDX_ALM_MIN  = 7'd3;
  localparam idx_t IDX_ALM_HOUR = 7'd5;
  localparam idx_t IDX_CTL_A    = 7'd10;
  localparam idx_t IDX_CTL_B    = 7'd11;
  localparam idx_t IDX_STAT     = 7'd12;
  localparam idx_t IDX_VALID    = 7'd13;

  localparam byte_t RST_CTL_A = 8'h26;
  localparam byte_t RST_CTL_B = 8'h02;
  localparam byte_t VALID_VAL = 8'h80;
  localparam byte_t EVEN_READ = 8'hFF;

  // Control B bit positions.
  localparam int B_FREEZE = 7;
  localparam int B_PER_EN = 6;
  localparam int B_ALM_EN = 5;
  localparam int B_UPD_EN = 4;

  // Status flag masks.
  localparam byte_t FLG_PERIODIC = 8'hC0;
  localparam byte_t FLG_ALARM    = 8'hA0;
  localparam byte_t FLG_UPDATE   = 8'h90;
endpackage

// File: rtl/rtcx_host_port.sv
module rtcx_host_port
  import rtcx_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_addr,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic [DW-1:0] rd_byte,
  output logic [IW-1:0] idx_q,
  output logic          acc_wr,
  output logic          acc_rd
);
  logic fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign acc_wr    = fire && req_wr && req_addr;
  assign acc_rd    = fire && !req_wr && req_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (fire && req_wr && !req_addr) idx_q <= req_wdata[IW-1:0];
      if (fire && !req_wr) begin
        rsp_valid <= 1'b1;
        rsp_data  <= req_addr ? rd_byte : DW'(EVEN_READ);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtcx_alarm_match.sv
module rtcx_alarm_match #(
  parameter int NF = 3,
  parameter int W  = 8
) (
  input  logic [NF-1:0][W-1:0] alarm_bytes,
  input  logic [NF-1:0][W-1:0] cur_bytes,
  output logic                 hit
);
  logic [NF-1:0] fld_ok;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign fld_ok[g] = (alarm_bytes[g][W-1:W-2] == 2'b11) ||
                       (alarm_bytes[g] == cur_bytes[g]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtcx_flag_unit.sv
module rtcx_flag_unit
  import rtcx_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_periodic,
  input  logic          upd_start,
  input  logic          upd_end,
  input  logic [DW-1:0] ctl_b,
  input  logic          alarm_hit,
  input  logic          wr_b_freeze,
  input  logic          rd_stat,
  output logic          uip,
  output logic [DW-1:0] status,
  output logic          irq
);
  logic          frozen;
  logic [DW-1:0] set_bits;
  logic [DW-1:0] kept;

  assign frozen = ctl_b[B_FREEZE];
  assign kept   = rd_stat ? '0 : status;

  always_comb begin
    set_bits = '0;
    if (tick_periodic && ctl_b[B_PER_EN]) set_bits |= DW'(FLG_PERIODIC);
    if (upd_end && !frozen) begin
      if (ctl_b[B_UPD_EN])              set_bits |= DW'(FLG_UPDATE);
      if (ctl_b[B_ALM_EN] && alarm_hit) set_bits |= DW'(FLG_ALARM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip    <= 1'b0;
      status <= '0;
    end else begin
      status <= kept | set_bits;
      if (wr_b_freeze || upd_end)   uip <= 1'b0;
      else if (upd_start && !frozen) uip <= 1'b1;
    end
  end

  assign irq = status[DW-1];
endmodule

// File: rtl/rtcx_regfile.sv
module rtcx_regfile
  import rtcx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_addr,
  input  logic              req_wr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              tick_periodic,
  input  logic              upd_start,
  input  logic              upd_end,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  output logic [BYTE_W-1:0] ctl_a,
  output logic [BYTE_W-1:0] ctl_b,
  output logic              irq
);
  byte_t mem [NUM_BYTES];
  idx_t  idx_q;
  logic  acc_wr, acc_rd;
  byte_t rd_byte, status;
  logic  uip, alarm_hit, wr_b_freeze, rd_stat;
  logic  wr_allowed;

  rtcx_host_port #(.IW(IDX_W), .DW(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_byte(rd_byte), .idx_q(idx_q), .acc_wr(acc_wr), .acc_rd(acc_rd)
  );

  assign wr_allowed = (idx_q != IDX_STAT) && (idx_q != IDX_VALID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= '0;
      mem[IDX_CTL_A] <= RST_CTL_A;
      mem[IDX_CTL_B] <= RST_CTL_B;
    end else if (acc_wr && wr_allowed) begin
      if (idx_q == IDX_CTL_A) mem[idx_q] <= {1'b0, req_wdata[BYTE_W-2:0]};
      else                    mem[idx_q] <= req_wdata;
    end
  end

  assign ctl_a = {uip, mem[IDX_CTL_A][BYTE_W-2:0]};
  assign ctl_b = mem[IDX_CTL_B];

  always_comb begin
    case (idx_q)
      IDX_CTL_A: rd_byte = ctl_a;
      IDX_STAT:  rd_byte = status;
      IDX_VALID: rd_byte = VALID_VAL;
      default:   rd_byte = mem[idx_q];
    endcase
  end

  assign wr_b_freeze = acc_wr && (idx_q == IDX_CTL_B) && req_wdata[B_FREEZE];
  assign rd_stat     = acc_rd && (idx_q == IDX_STAT);

  rtcx_alarm_match #(.NF(3), .W(BYTE_W)) u_alarm (
    .alarm_bytes({mem[IDX_ALM_HOUR], mem[IDX_ALM_MIN], mem[IDX_ALM_SEC]}),
    .cur_bytes({cur_hour, cur_min, cur_sec}),
    .hit(alarm_hit)
  );

  rtcx_flag_unit #(.DW(BYTE_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tick_periodic(tick_periodic), .upd_start(upd_start), .upd_end(upd_end),
    .ctl_b(ctl_b), .alarm_hit(alarm_hit), .wr_b_freeze(wr_b_freeze),
    .rd_stat(rd_stat), .uip(uip), .status(status), .irq(irq)
  );
endmodule

// File: rtl/rtcx_regfile_chk.sv
module rtcx_regfile_chk
  import rtcx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_addr,
  input logic              req_wr,
  input logic [BYTE_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BYTE_W-1:0] rsp_data,
  input logic              tick_periodic,
  input logic              upd_start,
  input logic              upd_end,
  input logic [BYTE_W-1:0] ctl_a,
  input logic [BYTE_W-1:0] ctl_b,
  input logic              irq,
  input logic [IDX_W-1:0]  idx_q
);
  logic freeze_wr;
  assign freeze_wr = req_valid && req_ready && req_wr && req_addr &&
                     (idx_q == IDX_CTL_B) && req_wdata[B_FREEZE];

  p_uip_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_start && !upd_end && !ctl_b[B_FREEZE] && !freeze_wr |=> ctl_a[7]);

  p_uip_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_end || freeze_wr) |=> !ctl_a[7]);

  p_periodic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_periodic && ctl_b[B_PER_EN] |=> irq);

  p_update_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end && !ctl_b[B_FREEZE] && ctl_b[B_UPD_EN] |=> irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !tick_periodic && !upd_end |=> !irq);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind rtcx_regfile rtcx_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .tick_periodic(tick_periodic), .upd_start(upd_start), .upd_end(upd_end),
  .ctl_a(ctl_a), .ctl_b(ctl_b), .irq(irq), .idx_q(idx_q)
);

// File: tb/test_rtcx_regfile.sv
`timescale 1ns/1ps
module test_rtcx_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_addr = 0, req_wr = 0, rsp_ready = 1;
  logic [7:0] req_wdata = 0, cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic tick_periodic = 0, upd_start = 0, upd_end = 0;
  logic req_ready, rsp_valid, irq;
  logic [7:0] rsp_data, ctl_a, ctl_b;

  int checks = 0, fails = 0;
  logic [7:0] m_mem [128];
  logic [6:0] m_idx;
  logic       m_uip;
  logic [7:0] m_c;
  logic [7:0] last_rsp;

  always #2 clk = ~clk;

  rtcx_regfile i_rtcx_regfile (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read();
    case (m_idx)
      7'd10:   return {m_uip, m_mem[10][6:0]};
      7'd12:   return m_c;
      7'd13:   return 8'h80;
      default: return m_mem[m_idx];
    endcase
  endfunction

  function automatic bit fld_ok(input logic [7:0] a, input logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  // One cycle: drive at negedge, update model, check at next negedge.
  task automatic op(input bit v, input bit a, input bit w, input logic [7:0] d,
                    input bit tk, input bit us, input bit ue);
    logic [7:0] exp, b, setb;
    bit rd, hit;
    rd  = v && !w;
    exp = a ? m_read() : 8'hFF;
    req_valid = v; req_addr = a; req_wr = w; req_wdata = d;
    tick_periodic = tk; upd_start = us; upd_end = ue;
    b    = m_mem[11];
    hit  = fld_ok(m_mem[1], cur_sec) && fld_ok(m_mem[3], cur_min) && fld_ok(m_mem[5], cur_hour);
    setb = 8'h00;
    if (tk && b[6]) setb |= 8'hC0;
    if (ue && !b[7] && b[4]) setb |= 8'h90;
    if (ue && !b[7] && b[5] && hit) setb |= 8'hA0;
    m_c = ((rd && a && m_idx == 7'd12) ? 8'h00 : m_c) | setb;
    if (v && w && a && m_idx == 7'd11 && d[7]) m_uip = 1'b0;
    else if (ue) m_uip = 1'b0;
    else if (us && !b[7]) m_uip = 1'b1;
    if (v && w && a && m_idx != 7'd12 && m_idx != 7'd13)
      m_mem[m_idx] = (m_idx == 7'd10) ? {1'b0, d[6:0]} : d;
    if (v && w && !a) m_idx = d[6:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; tick_periodic = 0; upd_start = 0; upd_end = 0;
    if (rd) begin
      chk(rsp_valid && rsp_data == exp, a ? "R1/R8 odd read" : "R1 even read", rsp_data, exp);
      last_rsp = rsp_data;
    end
    chk(irq == m_c[7], "R8 irq", irq, m_c[7]);
    chk(ctl_a == {m_uip, m_mem[10][6:0]}, "R3/R4 ctl_a", ctl_a, {m_uip, m_mem[10][6:0]});
  endtask

  task automatic wr_reg(input logic [6:0] i, input logic [7:0] d);
    op(1, 0, 1, {1'b0, i}, 0, 0, 0);
    op(1, 1, 1, d, 0, 0, 0);
  endtask

  task automatic rd_reg(input logic [6:0] i);
    op(1, 0, 1, {1'b0, i}, 0, 0, 0);
    op(1, 1, 0, 8'h00, 0, 0, 0);
  endtask

  function automatic logic [7:0] pool(input int k);
    case (k % 6)
      0: return 8'h30;
      1: return 8'h12;
      2: return 8'hC0;
      3: return 8'hFF;
      4: return 8'h45;
      default: return 8'h30;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_mem[10] = 8'h26; m_mem[11] = 8'h02;
    m_idx = 0; m_uip = 0; m_c = 0; last_rsp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk(ctl_a == 8'h26, "R2 ctl_a reset", ctl_a, 8'h26);
    chk(ctl_b == 8'h02, "R2 ctl_b reset", ctl_b, 8'h02);
    chk(irq == 1'b0, "R2 irq reset", irq, 0);
    rd_reg(12); chk(last_rsp == 8'h00, "R2 status reset", last_rsp, 8'h00);
    rd_reg(13); chk(last_rsp == 8'h80, "R2 index13 reset", last_rsp, 8'h80);
    rd_reg(10); chk(last_rsp == 8'h26, "R2 ctlA read", last_rsp, 8'h26);
    // R1 general byte, even read
    wr_reg(7'd40, 8'h5A); rd_reg(7'd40);
    chk(last_rsp == 8'h5A, "R1 byte readback", last_rsp, 8'h5A);
    op(1, 0, 0, 8'h00, 0, 0, 0);
    chk(last_rsp == 8'hFF, "R1 even read", last_rsp, 8'hFF);
    // R3/R4 UIP read-only and set/clear
    op(0, 0, 0, 0, 0, 1, 0);
    chk(ctl_a[7] == 1'b1, "R4 uip set", ctl_a[7], 1);
    wr_reg(10, 8'h00);
    chk(ctl_a == 8'h80, "R3 write A keeps uip", ctl_a, 8'h80);
    op(0, 0, 0, 0, 0, 0, 1);
    chk(ctl_a[7] == 1'b0, "R4 uip clear on end", ctl_a[7], 0);
    op(1, 0, 1, 8'd11, 0, 0, 0);
    op(1, 1, 1, 8'h82, 0, 1, 0);
    chk(ctl_a[7] == 1'b0, "R4 freeze write wins", ctl_a[7], 0);
    op(0, 0, 0, 0, 0, 1, 0);
    chk(ctl_a[7] == 1'b0, "R4 no uip while frozen", ctl_a[7], 0);
    // R5 periodic off then on
    wr_reg(11, 8'h02);
    op(0, 0, 0, 0, 1, 0, 0);
    chk(irq == 1'b0, "R5 tick ignored", irq, 0);
    wr_reg(11, 8'h42);
    op(0, 0, 0, 0, 1, 0, 0);
    chk(irq == 1'b1, "R5 tick raises", irq, 1);
    // R8 read clears, same-cycle event survives
    op(1, 0, 1, 8'd12, 0, 0, 0);
    op(1, 1, 0, 8'h00, 1, 0, 0);
    chk(last_rsp == 8'hC0, "R8 status value", last_rsp, 8'hC0);
    chk(irq == 1'b1, "R8 same-cycle flag kept", irq, 1);
    op(1, 1, 0, 8'h00, 0, 0, 0);
    op(1, 1, 0, 8'h00, 0, 0, 0);
    chk(last_rsp == 8'h00 && irq == 0, "R8 cleared", last_rsp, 8'h00);
    // R6 update flag
    wr_reg(11, 8'h12);
    op(0, 0, 0, 0, 0, 0, 1);
    rd_reg(12); chk(last_rsp == 8'h90, "R6 update flag", last_rsp, 8'h90);
    // R7 alarm match and miss
    wr_reg(1, 8'h30); wr_reg(3, 8'hC5); wr_reg(5, 8'h12); wr_reg(11, 8'h22);
    cur_sec = 8'h30; cur_min = 8'h59; cur_hour = 8'h12;
    op(0, 0, 0, 0, 0, 0, 1);
    rd_reg(12); chk(last_rsp == 8'hA0, "R7 alarm hit", last_rsp, 8'hA0);
    cur_hour = 8'h13;
    op(0, 0, 0, 0, 0, 0, 1);
    rd_reg(12); chk(last_rsp == 8'h00, "R7 alarm miss", last_rsp, 8'h00);
    // R9 status and index13 read-only
    wr_reg(12, 8'hFF); rd_reg(12);
    chk(last_rsp == 8'h00 && irq == 0, "R9 status write ignored", last_rsp, 8'h00);
    wr_reg(13, 8'h00); rd_reg(13);
    chk(last_rsp == 8'h80, "R9 index13 write ignored", last_rsp, 8'h80);
    // R10 back-pressure
    op(1, 0, 1, 8'd40, 0, 0, 0);
    rsp_ready = 0;
    req_valid = 1; req_addr = 1; req_wr = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && !req_ready, "R10 ready low while pending", req_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(rsp_valid && rsp_data == 8'h5A, "R10 data held", rsp_data, 8'h5A);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 taken", rsp_valid, 0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int k, ev;
      bit tk, us, ue;
      k  = $urandom_range(0, 9);
      ev = $urandom_range(0, 15);
      tk = ($urandom_range(0, 5) == 0);
      us = (ev == 0); ue = (ev == 1);
      cur_sec = pool($urandom_range(0, 5)); cur_min = pool($urandom_range(0, 5));
      cur_hour = pool($urandom_range(0, 5));
      case (k)
        0, 1: op(1, 0, 1, 8'($urandom_range(0, 15)), tk, us, ue);
        2:    op(1, 0, 1, 8'($urandom_range(0, 127)), tk, us, ue);
        3, 4: begin
          logic [7:0] d;
          d = (m_idx == 7'd11) ? (8'($urandom_range(0, 127)) | (($urandom_range(0, 3) == 0) ? 8'h80 : 8'h00))
                               : (($urandom_range(0, 1) == 0) ? pool($urandom_range(0, 5)) : 8'($urandom));
          op(1, 1, 1, d, tk, us, ue);
        end
        5, 6, 7: op(1, 1, 0, 8'h00, tk, us, ue);
        8:    op(1, 0, 0, 8'h00, tk, us, ue);
        default: op(0, 0, 0, 8'h00, tk, us, ue);
      endcase
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule